// File: doc/BRIEF.md
# Chained Serial DAC Command Sender

This block is the host end of a serial link to a string of identical 12-bit-command DAC devices. The devices are wired in series: the host data line enters the first device, and each device's serial output feeds the next device's serial input. The block therefore loads all devices with one long frame. The user offers one 12-bit command per device together with a flag per device saying whether that device is to be updated. On a start pulse the block builds one frame of `N_DEV` x 12 bits. Each device whose flag is clear gets the all-zero no-op word, so its registers stay as they were. The block shifts the frame out MSB first while chip select is low. It then raises chip select, and every device executes its command at that moment.

The bits that come back from the far end of the chain can be captured into a frame-wide register. While this capture is enabled, the serial clock is held to 4 MHz or slower. When it is disabled, the limit is 10 MHz. The user asks for a clock phase length in system clock cycles. The block raises that value to the smallest phase length the active rate cap allows.

Control is one state machine. **IDLE** moves to **SETUP** on `start`; this drives chip select low and the clock stays low. **SETUP** moves to **HIGH** after one phase (the first rising clock edge). **HIGH** moves to **LOW** after one phase when bits remain, or to **TAIL** after the last bit. **LOW** moves to **HIGH** after one phase. **TAIL** keeps chip select low with the clock low for one phase, then moves to **RECOVER**, which raises chip select. **RECOVER** holds chip select high for one phase, then returns to **IDLE**, and `done` pulses.

Top module: `dac_chain_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: Each frame has exactly `N_DEV`*12 rising edges of `sclk`, all while `cs_n` is 0.
- R3: The bits present on `mosi` at the rising edges of `sclk` are the word of device `N_DEV-1` (bits [12*N_DEV-1 -: 12] of `cmd_words`) first and the word of device 0 (bits [11:0]) last, each word MSB first.
- R4: A device whose `cmd_valid` bit is 0 receives twelve 0 bits (the no-op code 0x000) in its slot, whatever its `cmd_words` slice holds.
- R5: `sclk` is 0 whenever `cs_n` is 1, and `mosi` does not change while `sclk` is 1.
- R6: `cs_n` is low for exactly one phase (PH cycles, at least 40 ns) before the first rising edge of `sclk`.
- R7: Every high phase and every low phase between two rising edges lasts PH system cycles. PH is the larger of `HALF_CYC` and ceil(125 ns / `CLK_PERIOD_NS`) when capture is enabled, or the larger of `HALF_CYC` and ceil(50 ns / `CLK_PERIOD_NS`) when it is not.
- R8: After the last falling edge of `sclk`, `cs_n` stays low for PH cycles. It then stays high for PH cycles, with `busy` still 1, before the block accepts another start.
- R9: When `done` pulses, `rx_frame` holds the `miso` values sampled at the frame's rising edges of `sclk`, the first sampled bit in the MSB.
- R10: `done` is a one-cycle pulse that arrives with `busy` low and `cs_n` high. A `start` while `busy` is 1 is ignored and does not lengthen or restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a frame (taken in IDLE only) |
| cmd_words | input | 12*N_DEV | Command per device; slice 0 is the device nearest the host |
| cmd_valid | input | N_DEV | Per-device update flag; 0 sends the no-op word |
| miso | input | 1 | Serial data returned from the far end of the chain |
| busy | output | 1 | High from start acceptance until the block is back in IDLE |
| done | output | 1 | One-cycle pulse at the end of a frame |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select shared by the chain |
| mosi | output | 1 | Serial data to the first device |
| rx_frame | output | 12*N_DEV | Captured return bits, first bit in the MSB |

## Verification
The frame composer is tried with three patterns. With every device flagged, distinct words show that the slot order and bit order are right. With the middle device unflagged and its slice non-zero, the test shows that the no-op zeros replace the slice rather than pass it through. With no device flagged, the test shows that an all-zero frame still gets the full edge count and timing. Each run returns a different reply pattern on `miso`, so a bit-reversed or shifted capture cannot match by chance. A start pulse in the middle of a frame shows whether the machine ignores it or restarts.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    localparam int WORD_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_RECOVER
    } dcm_state_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/dcm_frame_builder.sv
module dcm_frame_builder #(
    parameter int N_DEV  = 3,
    parameter int WORD_W = 12
) (
    input  logic [N_DEV*WORD_W-1:0] words,
    input  logic [N_DEV-1:0]        valid,
    output logic [N_DEV*WORD_W-1:0] frame
);
    localparam logic [WORD_W-1:0] NOP_WORD = '0;

    // Slot i of the frame belongs to device i; the highest slot leaves first.
    for (genvar i = 0; i < N_DEV; i++) begin : g_slot
        assign frame[i*WORD_W +: WORD_W] = valid[i] ? words[i*WORD_W +: WORD_W] : NOP_WORD;
    end
endmodule

// File: rtl/dcm_phase_timer.sv
module dcm_phase_timer #(
    parameter int LIMIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

    // R7
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));
endmodule

// File: rtl/dac_chain_master.sv
module dac_chain_master #(
    parameter int N_DEV         = 3,
    parameter int CLK_PERIOD_NS = 20,
    parameter int HALF_CYC      = 3,
    parameter bit RX_EN         = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [N_DEV*dcm_pkg::WORD_W-1:0] cmd_words,
    input  logic [N_DEV-1:0]                cmd_valid,
    input  logic                            miso,
    output logic                            busy,
    output logic                            done,
    output logic                            sclk,
    output logic                            cs_n,
    output logic                            mosi,
    output logic [N_DEV*dcm_pkg::WORD_W-1:0] rx_frame
);
    import dcm_pkg::*;

    localparam int FRAME_W      = N_DEV * WORD_W;
    localparam int BIT_CW       = $clog2(FRAME_W);
    localparam int MIN_PHASE_NS = RX_EN ? 125 : 50;
    localparam int MIN_CYC      = ceil_div(MIN_PHASE_NS, CLK_PERIOD_NS);
    localparam int PH           = (HALF_CYC > MIN_CYC) ? HALF_CYC : MIN_CYC;

    dcm_state_t state, next;
    logic               expired;
    logic [FRAME_W-1:0] frame;
    logic [FRAME_W-1:0] tx_sr;
    logic [BIT_CW-1:0]  bitcnt;
    logic               last_bit;
    logic               cs_q, sclk_q, done_q;

    dcm_frame_builder #(.N_DEV(N_DEV), .WORD_W(WORD_W)) i_builder (
        .words (cmd_words),
        .valid (cmd_valid),
        .frame (frame)
    );

    dcm_phase_timer #(.LIMIT(PH)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (next != state),
        .expired (expired)
    );

    assign last_bit = (bitcnt == BIT_CW'(FRAME_W - 1));

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:    if (start)   next = ST_SETUP;
            ST_SETUP:   if (expired) next = ST_HIGH;
            ST_HIGH:    if (expired) next = last_bit ? ST_TAIL : ST_LOW;
            ST_LOW:     if (expired) next = ST_HIGH;
            ST_TAIL:    if (expired) next = ST_RECOVER;
            ST_RECOVER: if (expired) next = ST_IDLE;
            default:                 next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    // Registered pin levels, taken from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cs_q   <= !(next inside {ST_SETUP, ST_HIGH, ST_LOW, ST_TAIL});
            sclk_q <= (next == ST_HIGH);
            done_q <= (state == ST_RECOVER) && (next == ST_IDLE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr  <= '0;
            bitcnt <= '0;
        end else if (state == ST_IDLE && start) begin
            tx_sr  <= frame;
            bitcnt <= '0;
        end else if (state == ST_HIGH && next == ST_LOW) begin
            tx_sr  <= {tx_sr[FRAME_W-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
        end
    end

    if (RX_EN) begin : g_rx
        logic [FRAME_W-1:0] rx_sr;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rx_sr <= '0;
            else if (state != ST_HIGH && next == ST_HIGH)
                rx_sr <= {rx_sr[FRAME_W-2:0], miso};
        end
        assign rx_frame = rx_sr;
    end else begin : g_no_rx
        assign rx_frame = '0;
    end

    assign busy = (state != ST_IDLE);
    assign done = done_q;
    assign sclk = sclk_q;
    assign cs_n = cs_q;
    assign mosi = tx_sr[FRAME_W-1];

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |-> !sclk_q);

    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi));

    // R6
    cs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> (!cs_q && !$past(cs_q)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cs_q && !busy));
endmodule

// File: tb/test_dac_chain_master.sv
module test_dac_chain_master;
    localparam int N  = 3;
    localparam int FW = N * 12;
    // Capture on, 20 ns clock: ceil(125/20) = 7 cycles per phase (R7).
    localparam int PH = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [FW-1:0] cmd_words = '0;
    logic [N-1:0]  cmd_valid = '0;
    logic          miso = 1'b0;
    logic          busy, done, sclk, cs_n, mosi;
    logic [FW-1:0] rx_frame;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    dac_chain_master #(.N_DEV(N), .CLK_PERIOD_NS(20), .HALF_CYC(3), .RX_EN(1'b1)) i_dac_chain_master (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_words(cmd_words),
        .cmd_valid(cmd_valid), .miso(miso), .busy(busy), .done(done),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .rx_frame(rx_frame)
    );

    always #10 clk = ~clk;

    // Monitor state
    logic [FW-1:0] reply = '0;
    logic [FW-1:0] cap = '0;
    int rises = 0, idx = 0;
    int m_run = 0, m_cs_low = 0, m_setup = -1, m_tail = -1, m_gap = 0;
    int hi_min = 9999, hi_max = 0, lo_min = 9999, lo_max = 0;
    bit m_seen_rise = 0, m_bad_mosi = 0, m_bad_idle = 0;
    logic m_sclk_prev = 1'b0, m_cs_prev = 1'b1, m_mosi_prev = 1'b0;

    always @(posedge sclk) begin
        cap = {cap[FW-2:0], mosi};
        rises++;
        idx++;
    end

    always @(negedge sclk) begin
        miso = (idx < FW) ? reply[FW-1-idx] : 1'b0;
    end

    always @(negedge clk) begin
        if (sclk != m_sclk_prev) begin
            if (m_sclk_prev) begin
                if (m_run < hi_min) hi_min = m_run;
                if (m_run > hi_max) hi_max = m_run;
            end else if (m_seen_rise) begin
                if (m_run < lo_min) lo_min = m_run;
                if (m_run > lo_max) lo_max = m_run;
            end
            if (sclk && !m_seen_rise) begin
                m_setup = m_cs_low;
                m_seen_rise = 1;
            end
            m_run = 1;
        end else begin
            m_run++;
        end
        if (cs_n && !m_cs_prev) m_tail = m_run - 1;
        if (!cs_n) m_cs_low++;
        if (cs_n && busy) m_gap++;
        if (sclk && cs_n) m_bad_idle = 1;
        if (sclk && m_sclk_prev && mosi != m_mosi_prev) m_bad_mosi = 1;
        m_sclk_prev = sclk;
        m_cs_prev = cs_n;
        m_mosi_prev = mosi;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_monitor();
        cap = '0; rises = 0; idx = 0;
        m_cs_low = 0; m_setup = -1; m_tail = -1; m_gap = 0;
        hi_min = 9999; hi_max = 0; lo_min = 9999; lo_max = 0;
        m_seen_rise = 0; m_bad_mosi = 0; m_bad_idle = 0;
        miso = reply[FW-1];
    endtask

    function automatic logic [FW-1:0] expected_frame(input logic [FW-1:0] w, input logic [N-1:0] v);
        logic [FW-1:0] f;
        for (int i = 0; i < N; i++)
            f[i*12 +: 12] = v[i] ? w[i*12 +: 12] : 12'h000;
        return f;
    endfunction

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int k = 0; k < 5000 && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
    endtask

    task automatic run_frame(input logic [FW-1:0] w, input logic [N-1:0] v,
                             input logic [FW-1:0] rep, input bit poke_mid, input string tag);
        bit seen;
        logic [FW-1:0] exp_f;
        exp_f = expected_frame(w, v);
        reply = rep;
        @(posedge clk); #1;
        cmd_words = w; cmd_valid = v;
        clear_monitor();
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke_mid) begin
            repeat (100) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        wait_done(seen);
        check(seen, {"R10 done seen ", tag}, 64'(seen), 64'd1);
        check(!busy && cs_n, {"R10 done with idle ", tag}, 64'({busy, cs_n}), 64'd1);
        check(rises == FW, {"R2 edge count ", tag}, 64'(rises), 64'(FW));
        check(cap == exp_f, {"R3 R4 frame bits ", tag}, 64'(cap), 64'(exp_f));
        check(rx_frame == rep, {"R9 capture ", tag}, 64'(rx_frame), 64'(rep));
        check(m_setup == PH, {"R6 setup ", tag}, 64'(m_setup), 64'(PH));
        check(hi_min == PH && hi_max == PH, {"R7 high phase ", tag}, 64'(hi_max), 64'(PH));
        check(lo_min == PH && lo_max == PH, {"R7 low phase ", tag}, 64'(lo_max), 64'(PH));
        check(m_tail == PH, {"R8 tail ", tag}, 64'(m_tail), 64'(PH));
        check(m_gap == PH, {"R8 cs high gap ", tag}, 64'(m_gap), 64'(PH));
        check(!m_bad_mosi && !m_bad_idle, {"R5 mosi/sclk levels ", tag},
              64'({m_bad_mosi, m_bad_idle}), 64'd0);
        @(negedge clk);
        check(!done, {"R10 done width ", tag}, 64'(done), 64'd0);
        repeat (20) @(negedge clk);
        check(!busy && rises == FW, {"R10 no second frame ", tag}, 64'(rises), 64'(FW));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cs_n == 1'b1, "R1 cs_n", 64'(cs_n), 64'd1);
        check(sclk == 1'b0, "R1 sclk", 64'(sclk), 64'd0);
        check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        check(done == 1'b0, "R1 done", 64'(done), 64'd0);
    endtask

    // R3: all devices flagged, distinct words
    task automatic t_all_valid();
        run_frame({12'hA5C, 12'h3F1, 12'h80E}, 3'b111, 36'h9_3C5A_6E1B, 1'b0, "all");
    endtask

    // R4: middle device skipped although its slice is non-zero
    task automatic t_skip_middle();
        run_frame({12'h7FF, 12'hFFF, 12'h123}, 3'b101, 36'h5_5555_AAAA, 1'b0, "skip");
    endtask

    // R4: nothing flagged, whole frame is no-ops
    task automatic t_none();
        run_frame({12'hFFF, 12'hFFF, 12'hFFF}, 3'b000, 36'hF_0000_000F, 1'b0, "none");
    endtask

    // R10: start while busy is ignored
    task automatic t_start_busy();
        run_frame({12'h0C3, 12'hE18, 12'h6B2}, 3'b111, 36'h1_2345_6789, 1'b1, "busy");
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_all_valid();
        t_skip_middle();
        t_none();
        t_start_busy();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule